// File: doc/BRIEF.md
# Serially Configured Four-Input Lookup Cell

This block is one programmable logic cell of the kind found in reconfigurable fabrics. A sixteen-entry lookup table turns any Boolean function of four inputs into the output. An output flip-flop can register that result. Seventeen configuration cells hold the table contents and a one-bit output mode. These cells are not written in parallel. They form a shift register that is loaded one bit per clock from a serial input. The last cell drives a serial output, so a long row of cells can be chained and loaded from a single wire.

To program a cell, a controller raises the shift enable and presents seventeen bits, one per clock. The mode bit goes first. The table entries follow, from index fifteen down to index zero. Once the shift enable drops, the cell computes its function. The clock and the active-low reset are shared with neighbouring cells. Reset clears only the output flip-flop, so a reset never makes the fabric lose its programming.

Top module: `cfg_lut4_cell`

## Requirements
- R1: On every rising clock edge with `cfg_shift` high, the value on `cfg_si` enters the first configuration cell, and each cell takes the value of its predecessor.
- R2: While `cfg_shift` is low, every configuration cell holds its value, whatever `cfg_si` does. Both `cfg_so` and the computed function are unchanged.
- R3: `cfg_so` presents the mode cell at the far end of the chain. After 17 shifts, the first bit shifted in sits in the mode cell. Each further shift moves the next loaded bit onto `cfg_so`, in load order.
- R4: The lookup index is the 4-bit value {in_a,in_b,in_c,in_d}, with in_a as the most significant bit. The combinational result equals the table entry at that index, so any function of four variables can be programmed. The table entry at index k is the (17-k)-th bit shifted in, where the 1st bit is the mode bit.
- R5: With mode bit 0, `out_f` follows the table entry for the current inputs with no clock edge in between.
- R6: With mode bit 1, `out_f` shows the table entry captured at the most recent rising edge. It does not change between edges when the inputs change.
- R7: An active-low `rst_n` clears the output flip-flop at once, so `out_f` is 0 in registered mode. The configuration cells keep their contents through reset.
- R8: Loading the three-input odd-parity table (0x9696) makes `out_f` equal in_b^in_c^in_d for all sixteen input combinations. in_a has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain and the output flip-flop, shared by a cell group |
| rst_n | input | 1 | Asynchronous active-low reset of the output flip-flop |
| cfg_si | input | 1 | Serial configuration data into the first cell |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| in_a | input | 1 | Logic input, most significant lookup index bit |
| in_b | input | 1 | Logic input, index bit 2 |
| in_c | input | 1 | Logic input, index bit 1 |
| in_d | input | 1 | Logic input, least significant index bit |
| out_f | output | 1 | Cell output, combinational or registered per the mode bit |
| cfg_so | output | 1 | Serial configuration data out, the mode cell |

## Verification
The bench drives inputs on the falling edge. A combinational result is due in the same low phase, so it is read 1 ns after the inputs change. A registered result is due at the first rising edge after the inputs settle. It is read 1 ns after that edge, and it is also checked to be unchanged just before the edge. `cfg_so` moves one cell per enabled edge, so the bench reads it 1 ns after each shifting edge and compares it with the bit it loaded 17 positions earlier. Asynchronous reset is read 1 ns after `rst_n` falls, with no edge in between.

// File: rtl/cfg_lut4_pkg.sv
package cfg_lut4_pkg;
    localparam int LE_INPUTS = 4;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;
endpackage

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
    parameter int CELLS = 17
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [CELLS-1:0] cells
);
    typedef struct packed {
        logic [CELLS-1:0] cells;
    } chain_t;

    chain_t st_d, st_q;

    // cell 0 receives the serial input; the highest cell is the far end
    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.cells = {st_q.cells[CELLS-2:0], ser_in};
        end
    end

    // configuration storage carries no reset
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cells = st_q.cells;
endmodule

// File: rtl/cfg_lut_select.sv
module cfg_lut_select #(
    parameter int N_IN = 4,
    localparam int LEAVES = 1 << N_IN
) (
    input  logic [LEAVES-1:0] tbl_bits,
    input  logic [N_IN-1:0]   sel,
    output logic              lut_val
);
    // binary multiplexer tree; level L holds 2**L nodes and is steered
    // by select bit N_IN-1-L, so the root uses the most significant bit
    for (genvar L = 0; L < N_IN; L++) begin : g_lvl
        logic [(1 << L)-1:0] vec;
        logic [(2 << L)-1:0] below;
        if (L == N_IN - 1) begin : g_leaf
            assign below = tbl_bits;
        end else begin : g_inner
            assign below = g_lvl[L+1].vec;
        end
        for (genvar j = 0; j < (1 << L); j++) begin : g_node
            assign vec[j] = sel[N_IN-1-L] ? below[2*j+1] : below[2*j];
        end
    end

    assign lut_val = g_lvl[0].vec[0];
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
    import cfg_lut4_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lut_val,
    input  out_mode_e mode,
    output logic      f
);
    typedef struct packed {
        logic hold;
    } ostage_t;

    ostage_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hold = lut_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        f = (mode == OUT_REG) ? st_q.hold : lut_val;
    end
endmodule

// File: rtl/cfg_lut4_cell.sv
module cfg_lut4_cell
    import cfg_lut4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_si,
    input  logic cfg_shift,
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    input  logic in_d,
    output logic out_f,
    output logic cfg_so
);
    localparam int N_IN       = LE_INPUTS;
    localparam int TBL_BITS   = 1 << N_IN;
    localparam int CHAIN_BITS = TBL_BITS + 1;
    localparam int MODE_POS   = CHAIN_BITS - 1;

    logic [CHAIN_BITS-1:0] cfg_cells;
    logic [N_IN-1:0]       lut_sel;
    logic                  lut_val;
    out_mode_e             mode;

    cfg_shift_chain #(.CELLS(CHAIN_BITS)) u_chain (
        .clk      (clk),
        .shift_en (cfg_shift),
        .ser_in   (cfg_si),
        .cells    (cfg_cells)
    );

    assign lut_sel = {in_a, in_b, in_c, in_d};
    assign mode    = out_mode_e'(cfg_cells[MODE_POS]);
    assign cfg_so  = cfg_cells[MODE_POS];

    cfg_lut_select #(.N_IN(N_IN)) u_lut (
        .tbl_bits (cfg_cells[TBL_BITS-1:0]),
        .sel      (lut_sel),
        .lut_val  (lut_val)
    );

    cfg_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .lut_val (lut_val),
        .mode    (mode),
        .f       (out_f)
    );

    // R1: the serial input lands in the first cell on a shifting edge
    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> cfg_cells[0] == $past(cfg_si));

    // R3: the serial output advances by exactly one cell per shift
    assert_chain_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> cfg_so == $past(cfg_cells[MODE_POS-1]));

    // R2: no cell moves while the shift enable is low
    assert_hold_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |=> $stable(cfg_cells));

    // R6: registered output shows the lookup value of the previous edge
    assert_reg_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OUT_REG && $past(mode) == OUT_REG && $past(rst_n))
            |-> out_f == $past(lut_val));

    // R7: leaving reset in registered mode, the output starts cleared
    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && mode == OUT_REG) |-> !out_f);
endmodule

// File: tb/cfg_lut4_cell_bench.sv
module cfg_lut4_cell_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_si = 1'b0;
    logic cfg_shift = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0, in_d = 1'b0;
    logic out_f, cfg_so;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cfg_lut4_cell u_cfg_lut4_cell (
        .clk(clk), .rst_n(rst_n), .cfg_si(cfg_si), .cfg_shift(cfg_shift),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
        .out_f(out_f), .cfg_so(cfg_so)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // mode bit first, then table entries 15 down to 0
    task automatic load_cfg(input logic mode_bit, input logic [15:0] tbl);
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_si    = (i == 0) ? mode_bit : tbl[16-i];
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_si    = 1'b0;
    endtask

    task automatic set_in(input int idx);
        {in_a, in_b, in_c, in_d} = 4'(idx);
    endtask

    task automatic t_reset_state;
        load_cfg(1'b1, 16'hFFFF);
        #1 chk(out_f, 1'b0, "R7", "output while in reset");
        chk(cfg_so, 1'b1, "R3", "mode cell after load");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_comb(input logic [15:0] tbl, input string req);
        load_cfg(1'b0, tbl);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            set_in(i);
            #1 chk(out_f, tbl[i], req, $sformatf("comb index %0d", i));
        end
    endtask

    task automatic t_xor3;
        logic [15:0] tbl = 16'h9696;
        load_cfg(1'b0, tbl);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            set_in(i);
            #1 chk(out_f, in_b ^ in_c ^ in_d, "R8", $sformatf("parity index %0d", i));
        end
    endtask

    task automatic t_registered;
        logic [15:0] tbl = 16'h8001;
        int seq [5] = '{5, 15, 7, 0, 3};
        logic prev;
        load_cfg(1'b1, tbl);
        @(negedge clk);
        set_in(0);
        @(posedge clk);
        #1 chk(out_f, 1'b1, "R6", "registered setup");
        prev = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            set_in(seq[k]);
            #1 chk(out_f, prev, "R6", $sformatf("held before edge idx %0d", seq[k]));
            @(posedge clk);
            #1 chk(out_f, tbl[seq[k]], "R6", $sformatf("after edge idx %0d", seq[k]));
            prev = tbl[seq[k]];
        end
    endtask

    task automatic t_chain_out;
        logic [15:0] tbl = 16'h6C2B;
        load_cfg(1'b1, tbl);
        #1 chk(cfg_so, 1'b1, "R3", "first loaded bit at far end");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_si    = 1'b0;
            @(posedge clk);
            #1 chk(cfg_so, tbl[15-k], "R1", $sformatf("shift-out step %0d", k + 1));
        end
        @(negedge clk);
        cfg_shift = 1'b0;
    endtask

    task automatic t_hold;
        logic [15:0] tbl = 16'h3A5C;
        load_cfg(1'b0, tbl);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            cfg_si = ~cfg_si;
        end
        #1 chk(cfg_so, 1'b0, "R2", "mode cell after idle toggling");
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            cfg_si = i[0];
            set_in(i);
            #1 chk(out_f, tbl[i], "R2", $sformatf("table kept index %0d", i));
        end
    endtask

    task automatic t_reset_keep;
        logic [15:0] tbl = 16'h0010;
        load_cfg(1'b1, tbl);
        @(negedge clk);
        set_in(4);
        @(posedge clk);
        #1 chk(out_f, 1'b1, "R7", "registered one before reset");
        @(negedge clk);
        rst_n = 1'b0;
        #1 chk(out_f, 1'b0, "R7", "async clear");
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk(out_f, 1'b0, "R7", "cleared until next edge");
        chk(cfg_so, 1'b1, "R7", "mode cell kept through reset");
        @(posedge clk);
        #1 chk(out_f, 1'b1, "R7", "table kept through reset");
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_xor3();
        t_comb(16'hA5C3, "R4");
        t_comb(16'h1E78, "R5");
        t_registered();
        t_chain_out();
        t_hold();
        t_reset_keep();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule